// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This peripheral holds several independent 16-bit up-counters behind one small register bus. Each channel runs from the peripheral clock through its own prescaler. It compares its count against four compare registers and, on a match, can return the count to zero, latch a match flag, drive a compare output pin and request an interrupt. One shared start register sets which channels are running. Software starts or stops one channel with a read-modify-write of that register.

A typical use is a periodic tick. Software picks a prescale, loads compare A, selects clear-on-A and sets the channel's start bit. The channel then raises its interrupt once every compare A + 1 prescaled ticks. To acknowledge a match flag, software reads the status register and then writes the flag's bit as 0, with 1 in every other bit. A bare write of 0 with no read before it does not clear a flag.

Addressing uses byte addresses. Channel n occupies the 16-byte window starting at n*16. The shared start register sits at NCH*16, which is 0x30 with the default of three channels. Reads are combinational. A write takes effect at the clock edge that samples it.

Top module: `tmr_unit`

## Requirements
- R1: After reset every register reads 0, every channel is stopped, and every compare pin and interrupt output is 0.
- R2: The start register, at byte address 0x30 (bits [NCH-1:0]), runs channel n while bit n is 1 and freezes it while bit n is 0. It reads back as written, and a write to it changes only the running state.
- R3: The prescale code in control bits [2:0] divides the clock by 1, 4, 16 or 64 for codes 0 to 3; codes 4 to 7 alias by their low two bits. The prescaler phase restarts when a channel starts. After a start write, the count advances first D clock edges later, where D is the division.
- R4: The clear-select code in control bits [7:5] returns the counter to 0 when it leaves compare A (code 1), B (code 2), C (code 5) or D (code 6). Any other code never clears, so the counter wraps from 0xFFFF to 0.
- R5: With clear-on-A selected, the count sequence is 0..compare A, so the period is compare A + 1 prescaled ticks. The compare A flag is set at the edge where the count returns to 0.
- R6: Status bits [3:0] are the match flags for compare A, B, C and D. A flag is set on every prescaled tick where the count being left equals that compare register.
- R7: A flag clears only if a status read saw it set and a later status write carries 0 in its bit. A write of 0 with no read before it, or a write of 1, leaves the flag set.
- R8: A match that sets a flag in the same cycle as a clearing write leaves the flag set.
- R9: A channel's interrupt is the OR over bits [3:0] of (status AND interrupt-enable), with interrupt-enable at offset 4. It stays high until the flag or the enable is cleared.
- R10: I/O control bits [3:0] hold the compare-A output action. Writing code 1, 2 or 3 drives the pin to 0 at once; writing code 5, 6 or 7 drives it to 1. On a compare A match, codes 1/5 clear the pin, 2/6 set it and 3/7 toggle it. Code 0 leaves the pin unchanged.
- R11: A write to the counter loads it while the channel is stopped and is ignored while it runs.
- R12: The channel register offsets are: control 0, mode 1, I/O control 2, interrupt-enable 4, status 5, counter 6, and compares A..D at 8, 10, 12 and 14. Control, mode, I/O control, interrupt-enable and the compares read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe; also arms the flag acknowledge |
| bus_addr | input | 6 | Byte address: channel window or start register |
| bus_wdata | input | 16 | Write data; byte registers use bits [7:0] |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| cmp_out | output | 3 | Compare output pin per channel |
| irq | output | 3 | Interrupt request per channel |

## Verification
Read data is combinational, so each read result is due in the cycle the strobe is high. The scoreboard samples it on the falling edge of that same cycle. A register write shows up on the next cycle. A counter running from a start write at edge E has made floor(S/D) steps after the stopping write lands at edge E+S. The bench counts S from its own write and idle sequence, and it stops a channel before reading a count or flag so the sampled value is frozen. The set-wins case is placed so that the clearing write lands on exactly the edge where compare A matches, and the channel is stopped before the next match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_W = 4;
  localparam int NCMP  = 4;
  localparam int PS_W  = 6;

  localparam logic [OFS_W-1:0] OFS_CTRL = 4'd0;
  localparam logic [OFS_W-1:0] OFS_MODE = 4'd1;
  localparam logic [OFS_W-1:0] OFS_IOC  = 4'd2;
  localparam logic [OFS_W-1:0] OFS_IEN  = 4'd4;
  localparam logic [OFS_W-1:0] OFS_STAT = 4'd5;
  localparam logic [OFS_W-1:0] OFS_CNT  = 4'd6;

  localparam logic [2:0] CLR_ON_A = 3'd1;
  localparam logic [2:0] CLR_ON_B = 3'd2;
  localparam logic [2:0] CLR_ON_C = 3'd5;
  localparam logic [2:0] CLR_ON_D = 3'd6;

  // last prescaler phase before a tick
  function automatic logic [PS_W-1:0] ps_last(input logic [1:0] code);
    logic [PS_W-1:0] r;
    case (code)
      2'd0:    r = PS_W'(0);
      2'd1:    r = PS_W'(3);
      2'd2:    r = PS_W'(15);
      default: r = PS_W'(63);
    endcase
    return r;
  endfunction

  // which compare may clear the counter
  function automatic logic [NCMP-1:0] clr_mask(input logic [2:0] sel);
    logic [NCMP-1:0] m;
    case (sel)
      CLR_ON_A: m = 4'b0001;
      CLR_ON_B: m = 4'b0010;
      CLR_ON_C: m = 4'b0100;
      CLR_ON_D: m = 4'b1000;
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PS_W-1:0] ph_q, ph_d, last;

  assign last = ps_last(code);
  assign tick = run && (ph_q >= last);

  always_comb begin
    ph_d = ph_q;
    if (!run)             ph_d = '0;
    else if (ph_q >= last) ph_d = '0;
    else                  ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (ph_q == '0)); // R3
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    rdata,
  output logic             cmp_o,
  output logic             irq_o
);
  logic [7:0]      ctrl_q, ctrl_d, mode_q, mode_d, ioc_q, ioc_d, ien_q, ien_d;
  logic [NCMP-1:0] stat_q, stat_d, arm_q, arm_d, hit, clr_bits;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [NCMP-1:0][CW-1:0] cmp_v;
  logic            out_q, out_d, tick;
  logic            we_cnt, we_stat, we_ioc, rd_stat;

  assign we_cnt  = wr_en && (ofs == OFS_CNT);
  assign we_stat = wr_en && (ofs == OFS_STAT);
  assign we_ioc  = wr_en && (ofs == OFS_IOC);
  assign rd_stat = rd_en && (ofs == OFS_STAT);

  tmr_prescale u_ps (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (ctrl_q[1:0]),
    .tick (tick)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    logic [CW-1:0] val_q;
    logic          we;
    assign we = wr_en && ofs[3] && !ofs[0] && (ofs[2:1] == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (we) val_q <= wdata;
    end
    assign cmp_v[g] = val_q;
    assign hit[g]   = tick && (cnt_q == val_q);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    mode_d = mode_q;
    ioc_d  = ioc_q;
    ien_d  = ien_q;
    if (wr_en) begin
      case (ofs)
        OFS_CTRL: ctrl_d = wdata[7:0];
        OFS_MODE: mode_d = wdata[7:0];
        OFS_IOC:  ioc_d  = wdata[7:0];
        OFS_IEN:  ien_d  = wdata[7:0];
        default:  ;
      endcase
    end

    cnt_d = cnt_q;
    if (we_cnt && !run)
      cnt_d = wdata;
    else if (tick)
      cnt_d = (|(hit & clr_mask(ctrl_q[7:5]))) ? '0 : cnt_q + 1'b1;

    clr_bits = we_stat ? (arm_q & ~wdata[NCMP-1:0]) : '0;
    stat_d   = (stat_q & ~clr_bits) | hit;
    arm_d    = (rd_stat ? (arm_q | stat_q) : arm_q) & ~clr_bits;

    out_d = out_q;
    if (we_ioc) begin
      if (!wdata[3] && (wdata[1:0] != 2'd0)) out_d = wdata[2];
    end else if (hit[0] && !ioc_q[3]) begin
      case (ioc_q[1:0])
        2'd1:    out_d = 1'b0;
        2'd2:    out_d = 1'b1;
        2'd3:    out_d = ~out_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
      stat_q <= '0;
      arm_q  <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
      ioc_q  <= ioc_d;
      ien_q  <= ien_d;
      stat_q <= stat_d;
      arm_q  <= arm_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_CTRL: rdata[7:0]      = ctrl_q;
      OFS_MODE: rdata[7:0]      = mode_q;
      OFS_IOC:  rdata[7:0]      = ioc_q;
      OFS_IEN:  rdata[7:0]      = ien_q;
      OFS_STAT: rdata[NCMP-1:0] = stat_q;
      OFS_CNT:  rdata           = cnt_q;
      default:  if (ofs[3] && !ofs[0]) rdata = cmp_v[ofs[2:1]];
    endcase
  end

  assign cmp_o = out_q;
  assign irq_o = |(stat_q & ien_q[NCMP-1:0]);

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we_cnt) |=> $stable(cnt_q)); // R11

  AST_WRAP_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (ctrl_q[7:5] == CLR_ON_A) && (cnt_q == cmp_v[0])) |=> (cnt_q == '0) && stat_q[0]); // R5

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !we_stat && !(wr_en && (ofs == OFS_IEN))) |=> irq_o); // R9

  AST_PIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(we_ioc || hit[0])); // R10

  for (genvar b = 0; b < NCMP; b++) begin : g_ack_chk
    AST_ACK_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q[b]) |-> $past(arm_q[b])); // R7
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CW     = 16,
  parameter int ADDR_W = $clog2(NCH + 1) + OFS_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  output logic [NCH-1:0]    cmp_out,
  output logic [NCH-1:0]    irq
);
  localparam int SEL_W = ADDR_W - OFS_W;
  localparam logic [SEL_W-1:0] START_SEL = SEL_W'(NCH);

  logic [SEL_W-1:0]        sel;
  logic [OFS_W-1:0]        ofs;
  logic [NCH-1:0]          start_q, start_d;
  logic                    start_hit, start_we;
  logic [NCH-1:0][CW-1:0]  ch_rdata;

  assign sel       = bus_addr[ADDR_W-1:OFS_W];
  assign ofs       = bus_addr[OFS_W-1:0];
  assign start_hit = (sel == START_SEL) && (ofs == '0);
  assign start_we  = bus_wr && start_hit;

  always_comb start_d = start_we ? bus_wdata[NCH-1:0] : start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else        start_q <= start_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan #(.CW(CW)) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (start_q[g]),
      .wr_en(bus_wr && (sel == SEL_W'(g))),
      .rd_en(bus_rd && (sel == SEL_W'(g))),
      .ofs  (ofs),
      .wdata(bus_wdata),
      .rdata(ch_rdata[g]),
      .cmp_o(cmp_out[g]),
      .irq_o(irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (start_hit) bus_rdata = CW'(start_q);
    for (int i = 0; i < NCH; i++)
      if (sel == SEL_W'(i)) bus_rdata = ch_rdata[i];
  end

  AST_START_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(start_q) |-> $past(start_we)); // R2
endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, pin_chk = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  cmp_out, irq;
  int          checks = 0, errs = 0;

  typedef struct {
    bit          is_pin;
    logic [5:0]  addr;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];
  item_t it;
  logic [15:0] act;

  localparam logic [5:0] START = 6'h30;

  always #5 clk = ~clk;

  tmr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_out(cmp_out), .irq(irq)
  );

  function automatic logic [5:0] ra(input int ch, input int o);
    return 6'(ch * 16 + o);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string r);
    @(posedge clk); #2;
    bus_addr = a; bus_rd = 1'b1;
    sbq.push_back('{is_pin: 1'b0, addr: a, exp: e, req: r});
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  // expected value is {irq, cmp_out} of one channel
  task automatic pin(input int ch, input logic [1:0] e, input string r);
    @(posedge clk); #2;
    pin_chk = 1'b1;
    sbq.push_back('{is_pin: 1'b1, addr: 6'(ch), exp: 16'(e), req: r});
    @(posedge clk); #2;
    pin_chk = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // monitor: pops one expectation per strobe, samples mid-cycle
  always @(negedge clk) begin
    if (bus_rd || pin_chk) begin
      if (sbq.size() == 0) begin
        errs++;
        $display("FAIL scoreboard empty actual=%0h expected=none", bus_rdata);
      end else begin
        it  = sbq.pop_front();
        act = it.is_pin ? 16'({irq[it.addr[1:0]], cmp_out[it.addr[1:0]]}) : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errs++;
          $display("FAIL %s addr=%0h actual=%0h expected=%0h", it.req, it.addr, act, it.exp);
        end
      end
    end
  end

  initial begin
    idle(200000);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd(START, 16'h0000, "R1 start reg");
    rd(ra(0, 0), 16'h0000, "R1 ctrl");
    rd(ra(1, 6), 16'h0000, "R1 counter");
    rd(ra(2, 5), 16'h0000, "R1 status");
    pin(0, 2'b00, "R1 pins ch0");
    pin(2, 2'b00, "R1 pins ch2");

    // R12 offsets and readback
    wr(ra(1, 1), 16'h005A);
    rd(ra(1, 1), 16'h005A, "R12 mode readback");
    wr(ra(2, 14), 16'hBEEF);
    rd(ra(2, 14), 16'hBEEF, "R12 compare D readback");

    // R11 counter load when stopped, ignored while running
    wr(ra(0, 6), 16'h1234);
    rd(ra(0, 6), 16'h1234, "R11 load while stopped");
    wr(START, 16'h0001);
    wr(ra(0, 6), 16'h0000);
    wr(START, 16'h0000);
    rd(ra(0, 6), 16'h1238, "R11 write ignored while running");
    rd(ra(0, 5), 16'h0000, "R6 no spurious flag");

    // R4 no clear: wrap, R6 all four compares at 0
    wr(ra(0, 6), 16'hFFFE);
    wr(START, 16'h0001);
    idle(1);
    wr(START, 16'h0000);
    rd(ra(0, 6), 16'h0001, "R4 wrap through zero");
    rd(ra(0, 5), 16'h000F, "R6 flags A..D");
    wr(ra(0, 5), 16'h0000);
    rd(ra(0, 5), 16'h0000, "R7 read then write zero clears");

    // R3 prescaler
    wr(ra(0, 8), 16'h0100);
    wr(ra(0, 10), 16'h0100);
    wr(ra(0, 12), 16'h0100);
    wr(ra(0, 14), 16'h0100);
    wr(ra(0, 0), 16'h0001);
    wr(ra(0, 6), 16'h0000);
    wr(START, 16'h0001); idle(8); wr(START, 16'h0000);
    rd(ra(0, 6), 16'h0002, "R3 divide by 4");
    wr(ra(0, 0), 16'h0002);
    wr(ra(0, 6), 16'h0000);
    wr(START, 16'h0001); idle(30); wr(START, 16'h0000);
    rd(ra(0, 6), 16'h0002, "R3 divide by 16");
    wr(ra(0, 0), 16'h0003);
    wr(ra(0, 6), 16'h0000);
    wr(START, 16'h0001); idle(62); wr(START, 16'h0000);
    rd(ra(0, 6), 16'h0001, "R3 divide by 64");
    wr(ra(0, 0), 16'h0001);
    wr(ra(0, 6), 16'h0000);
    wr(START, 16'h0001); idle(1); wr(START, 16'h0000);
    wr(START, 16'h0001); idle(1); wr(START, 16'h0000);
    rd(ra(0, 6), 16'h0000, "R3 phase restarts on start");

    // R8 set wins over clear, R5 wrap
    wr(ra(0, 0), 16'h0020);
    wr(ra(0, 8), 16'h0003);
    wr(ra(0, 6), 16'h0000);
    wr(START, 16'h0001); idle(3); wr(START, 16'h0000);
    wr(ra(0, 6), 16'h0000);
    wr(START, 16'h0001);
    rd(ra(0, 5), 16'h0001, "R8 flag before clear");
    wr(ra(0, 5), 16'h00FE);
    wr(START, 16'h0000);
    rd(ra(0, 5), 16'h0001, "R8 set wins");
    rd(ra(0, 6), 16'h0002, "R5 period compareA+1");

    // R2 R4 R5 R6 R9: two channels from one start write
    wr(ra(1, 8), 16'h0004);
    wr(ra(1, 10), 16'h0002);
    wr(ra(1, 12), 16'h0100);
    wr(ra(1, 14), 16'h0100);
    wr(ra(1, 0), 16'h0020);
    wr(ra(1, 4), 16'h0001);
    wr(ra(2, 8), 16'h0100);
    wr(ra(2, 10), 16'h0002);
    wr(ra(2, 12), 16'h0100);
    wr(ra(2, 14), 16'h0100);
    wr(ra(2, 0), 16'h0040);
    wr(START, 16'h0006); idle(5); wr(START, 16'h0000);
    rd(ra(1, 6), 16'h0002, "R5 clear on A count");
    rd(ra(2, 6), 16'h0001, "R4 clear on B count");
    rd(ra(0, 6), 16'h0002, "R2 unselected channel frozen");
    pin(1, 2'b10, "R9 irq with enable");
    pin(2, 2'b00, "R9 no irq without enable");

    // R7 acknowledge protocol on ch1
    wr(ra(1, 5), 16'h0000);
    rd(ra(1, 5), 16'h0003, "R7 write without read keeps flags");
    wr(ra(1, 5), 16'h00FE);
    rd(ra(1, 5), 16'h0002, "R7 clear A only");
    pin(1, 2'b00, "R9 irq drops after clear");
    wr(ra(1, 5), 16'h0000);
    rd(ra(1, 5), 16'h0000, "R7 armed B clears");
    wr(ra(2, 4), 16'h0002);
    pin(2, 2'b10, "R9 enable B raises irq");

    // R4 clear on C and D
    wr(ra(2, 0), 16'h00A0);
    wr(ra(2, 12), 16'h0003);
    wr(ra(2, 6), 16'h0000);
    wr(START, 16'h0004); idle(5); wr(START, 16'h0000);
    rd(ra(2, 6), 16'h0003, "R4 clear on C");
    wr(ra(2, 0), 16'h00C0);
    wr(ra(2, 14), 16'h0001);
    wr(ra(2, 12), 16'h0100);
    wr(ra(2, 6), 16'h0000);
    wr(START, 16'h0004); idle(5); wr(START, 16'h0000);
    rd(ra(2, 6), 16'h0001, "R4 clear on D");
    wr(ra(2, 4), 16'h0000);
    pin(2, 2'b00, "R9 enable off drops irq");

    // R10 output actions on ch2
    wr(ra(2, 2), 16'h0007);
    pin(2, 2'b01, "R10 initial 1");
    wr(ra(2, 0), 16'h0020);
    wr(ra(2, 8), 16'h0002);
    wr(ra(2, 6), 16'h0000);
    wr(START, 16'h0004); idle(2); wr(START, 16'h0000);
    pin(2, 2'b00, "R10 toggle on match");
    wr(ra(2, 2), 16'h0002);
    pin(2, 2'b00, "R10 initial 0");
    wr(ra(2, 6), 16'h0000);
    wr(START, 16'h0004); idle(2); wr(START, 16'h0000);
    pin(2, 2'b01, "R10 set on match");
    wr(ra(2, 2), 16'h0000);
    pin(2, 2'b01, "R10 retain code");
    wr(ra(2, 2), 16'h0005);
    wr(ra(2, 6), 16'h0000);
    wr(START, 16'h0004); idle(2); wr(START, 16'h0000);
    pin(2, 2'b00, "R10 clear on match");

    // R2 start readback
    wr(START, 16'h0005);
    rd(START, 16'h0005, "R2 start readback");
    wr(START, 16'h0000);

    idle(2);
    report();
    $finish;
  end
endmodule